// File: doc/BRIEF.md
# Alarm Response Controller

This block is a small synchronous sequential controller that models how a sleeper reacts to an alarm. It has three states: sleeping, awake but lying in bed, and out of bed. Each rising clock edge it reads two single-bit inputs. One says the alarm is sounding. The other says the current day is a working day. From these inputs and its current state it picks the next state and decides whether to ask for the alarm to be silenced.

The silence request is a Mealy output, so it depends on both the state and the inputs. An elaboration-time parameter selects how the request is presented:

- **Immediate style (default):** the request is driven combinationally in the same cycle.
- **Registered style:** the request passes through a flip-flop and appears one clock later.

The current state code is brought out on a port for observation. A synchronous active-high reset returns the machine to the sleeping state and clears the registered request.

Top module: `wake_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is sleeping (code 00) and, in both output styles, `turn_off_o` is 0 after that edge while `alarm_i` is 0.
- R2: In the sleeping state (00) with `alarm_i` = 0, the state stays 00 and `turn_off_o` is 0 for either value of `weekday_i`.
- R3: In the sleeping state (00) with `alarm_i` = 1, the next state is in-bed (01) and the silence request is 1 for either value of `weekday_i`.
- R4: In the in-bed state (01) with `alarm_i` = 1, the state stays 01 and the silence request is 1 for either value of `weekday_i`.
- R5: In the in-bed state (01) with `alarm_i` = 0 and `weekday_i` = 1, the next state is up (10) and the silence request is 0.
- R6: In the in-bed state (01) with `alarm_i` = 0 and `weekday_i` = 0, the next state is sleeping (00) and the silence request is 0.
- R7: The up state (10) is left only by reset. It holds for all four input combinations and never requests silencing.
- R8: `state_o` only ever shows the codes 00, 01 or 10.
- R9: With `OUT_REGISTERED` = 0, `turn_off_o` reflects the current state and inputs in the same cycle, before the next edge.
- R10: With `OUT_REGISTERED` = 1, `turn_off_o` after a rising edge equals the request computed from the state and inputs present just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| alarm_i | input | 1 | Alarm is sounding |
| weekday_i | input | 1 | Today is a working day |
| turn_off_o | output | 1 | Request to silence the alarm |
| state_o | output | 2 | Current state code (00 sleeping, 01 in bed, 10 up) |

## Verification
The bench builds two copies of the block side by side and drives them with the same stimulus:

- one with `OUT_REGISTERED` = 0, the immediate style;
- one with `OUT_REGISTERED` = 1, the registered style.

Both copies must follow the same state trajectory. This lets every scenario check the same-cycle request on one copy and the one-cycle-late request on the other. Any divergence between the two output paths, or a registered output that leaks through early, is therefore visible.

// File: rtl/wake_pkg.sv
package wake_pkg;

    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_ASLEEP = 2'b00,
        ST_INBED  = 2'b01,
        ST_UP     = 2'b10
    } wake_state_e;

    typedef struct packed {
        wake_state_e st;
    } wake_regs_t;

endpackage

// File: rtl/wake_step.sv
module wake_step
    import wake_pkg::*;
(
    input  wake_state_e cur_i,
    input  logic        alarm_i,
    input  logic        weekday_i,
    output wake_state_e nxt_o,
    output logic        req_o
);

    always_comb begin
        nxt_o = ST_ASLEEP;
        req_o = 1'b0;
        case (cur_i)
            ST_ASLEEP: begin
                if (alarm_i) begin
                    nxt_o = ST_INBED;
                    req_o = 1'b1;
                end else begin
                    nxt_o = ST_ASLEEP;
                end
            end
            ST_INBED: begin
                if (alarm_i) begin
                    nxt_o = ST_INBED;
                    req_o = 1'b1;
                end else if (weekday_i) begin
                    nxt_o = ST_UP;
                end else begin
                    nxt_o = ST_ASLEEP;
                end
            end
            ST_UP: begin
                nxt_o = ST_UP;
            end
            default: begin
                // unused code 11 falls back to sleeping, request low
                nxt_o = ST_ASLEEP;
                req_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/wake_out_stage.sv
module wake_out_stage #(
    parameter bit REGISTERED = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic req_o
);

    generate
        if (REGISTERED) begin : g_reg
            logic req_d;
            logic req_q;

            always_comb begin
                req_d = req_i;
                if (rst) req_d = 1'b0;
            end

            always_ff @(posedge clk) begin
                req_q <= req_d;
            end

            assign req_o = req_q;
        end else begin : g_imm
            logic unused_clk_rst;
            assign unused_clk_rst = ^{clk, rst};
            assign req_o = req_i;
        end
    endgenerate

endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
    import wake_pkg::*;
#(
    parameter bit OUT_REGISTERED = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               alarm_i,
    input  logic               weekday_i,
    output logic               turn_off_o,
    output logic [STATE_W-1:0] state_o
);

    wake_regs_t  regs_d;
    wake_regs_t  regs_q;
    wake_state_e step_nxt;
    logic        step_req;

    wake_step u_step (
        .cur_i     (regs_q.st),
        .alarm_i   (alarm_i),
        .weekday_i (weekday_i),
        .nxt_o     (step_nxt),
        .req_o     (step_req)
    );

    always_comb begin
        regs_d    = regs_q;
        regs_d.st = step_nxt;
        if (rst) regs_d.st = ST_ASLEEP;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    wake_out_stage #(
        .REGISTERED (OUT_REGISTERED)
    ) u_out (
        .clk   (clk),
        .rst   (rst),
        .req_i (step_req),
        .req_o (turn_off_o)
    );

    assign state_o = regs_q.st;

endmodule

// File: rtl/wake_ctrl_chk.sv
module wake_ctrl_chk #(
    parameter bit OUT_REGISTERED = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       alarm_i,
    input logic       weekday_i,
    input logic       turn_off_o,
    input logic [1:0] state_o
);

    logic want_req;
    assign want_req = alarm_i && (state_o == 2'b00 || state_o == 2'b01);

    p_reset_r1: assert property (@(posedge clk) rst |=> (state_o == 2'b00));

    p_asleep_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b00 && !alarm_i) |=> (state_o == 2'b00));

    p_wake_r3: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b00 && alarm_i) |=> (state_o == 2'b01));

    p_inbed_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b01 && alarm_i) |=> (state_o == 2'b01));

    p_get_up_r5: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b01 && !alarm_i && weekday_i) |=> (state_o == 2'b10));

    p_back_to_sleep_r6: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b01 && !alarm_i && !weekday_i) |=> (state_o == 2'b00));

    p_up_absorbing_r7: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b10) |=> (state_o == 2'b10));

    p_legal_code_r8: assert property (@(posedge clk) disable iff (rst)
        state_o != 2'b11);

    generate
        if (OUT_REGISTERED) begin : g_reg_chk
            p_late_req_r10: assert property (@(posedge clk) disable iff (rst)
                want_req |=> turn_off_o);
            p_late_quiet_r10: assert property (@(posedge clk) disable iff (rst)
                !want_req |=> !turn_off_o);
        end else begin : g_imm_chk
            p_same_cycle_r9: assert property (@(posedge clk) disable iff (rst)
                turn_off_o == want_req);
        end
    endgenerate

endmodule

bind wake_ctrl wake_ctrl_chk #(
    .OUT_REGISTERED (OUT_REGISTERED)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .alarm_i    (alarm_i),
    .weekday_i  (weekday_i),
    .turn_off_o (turn_off_o),
    .state_o    (state_o)
);

// File: tb/wake_ctrl_test.sv
module wake_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       alarm = 1'b0;
    logic       weekday = 1'b0;
    logic       off_imm;
    logic       off_reg;
    logic [1:0] st_imm;
    logic [1:0] st_reg;
    logic [1:0] st_m = 2'b00;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    wake_ctrl #(.OUT_REGISTERED(1'b0)) uut (
        .clk(clk), .rst(rst), .alarm_i(alarm), .weekday_i(weekday),
        .turn_off_o(off_imm), .state_o(st_imm)
    );

    wake_ctrl #(.OUT_REGISTERED(1'b1)) uut_reg (
        .clk(clk), .rst(rst), .alarm_i(alarm), .weekday_i(weekday),
        .turn_off_o(off_reg), .state_o(st_reg)
    );

    function automatic logic [1:0] ref_next(logic [1:0] s, logic a, logic w);
        case (s)
            2'b00:   return a ? 2'b01 : 2'b00;
            2'b01:   return a ? 2'b01 : (w ? 2'b10 : 2'b00);
            2'b10:   return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic ref_req(logic [1:0] s, logic a);
        return a && (s == 2'b00 || s == 2'b01);
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // one clock of stimulus: checks same-cycle request, next state and late request
    task automatic step(input logic a, input logic w, input string req);
        logic [1:0] en;
        logic       eo;
        en = ref_next(st_m, a, w);
        eo = ref_req(st_m, a);
        @(negedge clk);
        alarm = a;
        weekday = w;
        #1;
        check({req, " R9 same-cycle request"}, {1'b0, off_imm}, {1'b0, eo});
        @(posedge clk);
        #1;
        st_m = en;
        check({req, " state"}, st_imm, en);
        check({req, " R8 state (registered copy)"}, st_reg, en);
        check({req, " R10 late request"}, {1'b0, off_reg}, {1'b0, eo});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        alarm = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        st_m = 2'b00;
        check("R1 state after reset", st_imm, 2'b00);
        check("R1 state after reset (registered copy)", st_reg, 2'b00);
        check("R1 request after reset", {1'b0, off_imm}, 2'b00);
        check("R1 registered request after reset", {1'b0, off_reg}, 2'b00);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_idle_sleep();
        step(1'b0, 1'b0, "R2 idle weekend");
        step(1'b0, 1'b1, "R2 idle weekday");
        step(1'b0, 1'b0, "R2 idle again");
    endtask

    task automatic t_ring_and_stay();
        step(1'b1, 1'b1, "R3 ring on weekday");
        step(1'b1, 1'b0, "R4 still ringing weekend");
        step(1'b1, 1'b1, "R4 still ringing weekday");
    endtask

    task automatic t_weekend_snooze();
        step(1'b0, 1'b0, "R6 weekend back to sleep");
        step(1'b1, 1'b0, "R3 ring on weekend");
        step(1'b0, 1'b0, "R6 weekend back to sleep twice");
    endtask

    task automatic t_weekday_up();
        step(1'b1, 1'b0, "R3 ring before rising");
        step(1'b0, 1'b1, "R5 weekday get up");
        step(1'b0, 1'b0, "R7 up idle weekend");
        step(1'b0, 1'b1, "R7 up idle weekday");
        step(1'b1, 1'b0, "R7 up alarm weekend");
        step(1'b1, 1'b1, "R7 up alarm weekday");
    endtask

    task automatic t_reset_from_up();
        do_reset();
        step(1'b0, 1'b1, "R1 R2 sleeping after reset from up");
    endtask

    initial begin
        do_reset();
        t_idle_sleep();
        t_ring_and_stay();
        t_weekend_snooze();
        t_weekday_up();
        t_reset_from_up();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule